// File: doc/BRIEF.md
# Telephone Terminal Control Register and Key-Scan Port

This block is the processor side of a telephone terminal controller. A host processor reaches it over an 8-bit data bus with a 2-bit address, an active-low chip select, an active-low write strobe and an active-low read strobe. The bus is split at the ports into an input path, an output path and an output-enable.

On a write, the two address bits and the two most significant data bits together pick a target. The remaining six data bits are stored into that target. A few targets store nothing and instead emit a one-cycle action pulse: an interrupt release and a watchdog kick. One target updates the open-drain key-scan drive port. On a read, the eight key-scan sense lines are placed on the bus. The strobes are asynchronous to the system clock. They are synchronized inside the block, and every stored field is then presented as a plain output for the tone, gain, path, display-bias, power and codec logic elsewhere on the chip.

Top module: `ctl_keyscan_if`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, every stored field reads zero, `key_pull_low` is all zero (all lines released), `cpu_doe` is low and both pulses are low.
- R2: A write takes effect only on a rising edge of `cpu_wr_n` while `cpu_cs_n` is low, and appears at the outputs no later than 3 clock edges after that rise. Strobe activity while `cpu_cs_n` is high changes no output.
- R3: While `cpu_cs_n` and `cpu_rd_n` are both low, `cpu_doe` is 1 and `cpu_dout` equals `key_sense`. In every other case `cpu_doe` is 0.
- R4: Address 0 with sub-address `cpu_din[7:6]` = 0, 1 or 2 writes `cpu_din[5:0]` into `tone_enable`, `tone_setup` or `dtmf_setup` respectively. Sub-address 3 stores nothing.
- R5: Address 1 writes `cpu_din[5:0]` into `rx_gain`, `tx_gain`, `spk_gain` or `pad_gain` for sub-address 0, 1, 2 or 3.
- R6: Address 2 with sub-address 0 or 1 writes `cpu_din[5:0]` into `path_sw_lo` or `path_sw_hi`. Sub-address 2 writes `cpu_din[1:0]` into `gp_latch`.
- R7: Address 2 with sub-address 3 raises `wdog_kick` for exactly one clock cycle and changes no stored field.
- R8: Address 3 with sub-address 3 uses `cpu_din[5:4]` as a function code. Code 0 raises `irq_release` for exactly one cycle and stores nothing. Codes 1, 2 and 3 write `cpu_din[3:0]` into `lcd_bias`, `power_ctl` or `codec_ctl`.
- R9: Address 3 with sub-address 2 controls the key-scan drive, where a 1 in `key_pull_low` means the line is pulled to 0 and a 0 means released. If `cpu_din[5]` is 1, every line takes the value of `cpu_din[4]`. Otherwise only line `cpu_din[2:0]` takes the value of `cpu_din[3]`.
- R10: Address 3 with sub-address 0 or 1 changes no output and produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_cs_n | input | 1 | Chip select, active low, asynchronous |
| cpu_wr_n | input | 1 | Write strobe, active low, captured on its rising edge |
| cpu_rd_n | input | 1 | Read strobe, active low |
| cpu_addr | input | 2 | Register group address |
| cpu_din | input | 8 | Data bus, input direction |
| cpu_dout | output | 8 | Data bus, output direction |
| cpu_doe | output | 1 | Data bus output enable |
| key_sense | input | 8 | Key-scan sense lines |
| key_pull_low | output | 8 | Open-drain key-scan drive, 1 = pull low |
| tone_enable | output | 6 | Tone on/off field |
| tone_setup | output | 6 | Tone level/frequency field |
| dtmf_setup | output | 6 | Push-button tone field |
| rx_gain | output | 6 | Receive and side-tone gain field |
| tx_gain | output | 6 | Transmit-side gain field |
| spk_gain | output | 6 | Speaker pre-amplifier gain field |
| pad_gain | output | 6 | Receive pad and incoming-tone gain field |
| path_sw_lo | output | 6 | Speech path switch bank, low |
| path_sw_hi | output | 6 | Speech path switch bank, high |
| gp_latch | output | 2 | General-purpose latch outputs |
| lcd_bias | output | 4 | Display bias level field |
| power_ctl | output | 4 | Power control field |
| codec_ctl | output | 4 | Companding law and loopback field |
| irq_release | output | 1 | One-cycle interrupt release pulse |
| wdog_kick | output | 1 | One-cycle watchdog restart pulse |

## Verification
The assertions assume the processor keeps `cpu_addr` and `cpu_din` steady from before the write strobe falls until several clocks after it rises. They also assume that chip select stays low across that window, and that each strobe phase lasts at least two clocks, so that every rise is seen once through the synchronizer. The bench changes inputs only on falling clock edges. Every write holds select, address and data for the strobe plus four further clocks, and leaves the strobe low for two clocks. Random writes mix selected and unselected cycles but never shorten these windows.

// File: rtl/ckr_pkg.sv
package ckr_pkg;

   // write targets; the nine 6-bit fields come first, the three 4-bit
   // fields are consecutive, their order is relied on by ckr_regfile
   typedef enum logic [4:0] {
      TG_NONE,
      TG_TONE_EN,
      TG_TONE_SET,
      TG_DTMF,
      TG_RXG,
      TG_TXG,
      TG_SPKG,
      TG_PADG,
      TG_PATH_LO,
      TG_PATH_HI,
      TG_LATCH,
      TG_WDOG,
      TG_KEYS,
      TG_IRQ,
      TG_LCD,
      TG_PWR,
      TG_CODEC
   } ckr_tgt_e;

   localparam int unsigned CKR_NFLD = 9;
   localparam int unsigned CKR_NSUB = 3;

endpackage

// File: rtl/ckr_sync.sv
module ckr_sync #(
   parameter int unsigned  W       = 8,
   parameter int unsigned  STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < int'(STAGES); s++) stg[s] <= RST_VAL;
      end else begin
         stg[0] <= d;
         for (int s = 1; s < int'(STAGES); s++) stg[s] <= stg[s-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/ckr_capture.sv
module ckr_capture #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              wr_n,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] din,
   output logic              we,
   output logic [1:0]        waddr,
   output logic [DATA_W-1:0] wdata
);

   localparam int unsigned    VW   = DATA_W + 4;
   localparam int unsigned    WR_B = VW - 2;
   localparam int unsigned    CS_B = VW - 1;
   localparam logic [VW-1:0]  IDLE = {2'b11, {(DATA_W+2){1'b0}}};

   logic [VW-1:0] raw;
   logic [VW-1:0] syn;
   logic          wr_prev;

   assign raw = {cs_n, wr_n, addr, din};

   ckr_sync #(.W(VW), .STAGES(STAGES), .RST_VAL(IDLE)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw),
      .q     (syn)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wr_prev <= 1'b1;
      else        wr_prev <= syn[WR_B];
   end

   assign we    = syn[WR_B] & ~wr_prev & ~syn[CS_B];
   assign waddr = syn[DATA_W +: 2];
   assign wdata = syn[DATA_W-1:0];

   // a strobe rise yields one write enable, never two in a row
   p_we_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> !we);

endmodule

// File: rtl/ckr_decode.sv
module ckr_decode
   import ckr_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] data,
   output ckr_tgt_e          tgt
);

   logic [1:0] sub;
   logic [1:0] fn;

   assign sub = data[DATA_W-1 -: 2];
   assign fn  = data[DATA_W-3 -: 2];

   always_comb begin
      tgt = TG_NONE;
      unique case (addr)
         2'd0: begin
            unique case (sub)
               2'd0:    tgt = TG_TONE_EN;
               2'd1:    tgt = TG_TONE_SET;
               2'd2:    tgt = TG_DTMF;
               default: tgt = TG_NONE;
            endcase
         end
         2'd1: begin
            unique case (sub)
               2'd0:    tgt = TG_RXG;
               2'd1:    tgt = TG_TXG;
               2'd2:    tgt = TG_SPKG;
               default: tgt = TG_PADG;
            endcase
         end
         2'd2: begin
            unique case (sub)
               2'd0:    tgt = TG_PATH_LO;
               2'd1:    tgt = TG_PATH_HI;
               2'd2:    tgt = TG_LATCH;
               default: tgt = TG_WDOG;
            endcase
         end
         default: begin
            if (sub == 2'd2) begin
               tgt = TG_KEYS;
            end else if (sub == 2'd3) begin
               unique case (fn)
                  2'd0:    tgt = TG_IRQ;
                  2'd1:    tgt = TG_LCD;
                  2'd2:    tgt = TG_PWR;
                  default: tgt = TG_CODEC;
               endcase
            end
         end
      endcase
   end

endmodule

// File: rtl/ckr_regfile.sv
module ckr_regfile
   import ckr_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned GPL_W  = 2,
   localparam int unsigned FLD_W = DATA_W - 2,
   localparam int unsigned SUB_W = DATA_W - 4
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                we,
   input  ckr_tgt_e                            tgt,
   input  logic [DATA_W-1:0]                   wdata,
   output logic [CKR_NFLD-1:0][FLD_W-1:0]      fld_q,
   output logic [CKR_NSUB-1:0][SUB_W-1:0]      sub_q,
   output logic [GPL_W-1:0]                    gpl_q,
   output logic                                irq_release,
   output logic                                wdog_kick
);

   for (genvar i = 0; i < int'(CKR_NFLD); i++) begin : g_fld
      localparam ckr_tgt_e MY_TGT = ckr_tgt_e'(int'(TG_TONE_EN) + i);
      logic [FLD_W-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                    r <= '0;
         else if (we && tgt == MY_TGT)  r <= wdata[FLD_W-1:0];
      end
      assign fld_q[i] = r;
   end

   for (genvar j = 0; j < int'(CKR_NSUB); j++) begin : g_sub
      localparam ckr_tgt_e MY_TGT = ckr_tgt_e'(int'(TG_LCD) + j);
      logic [SUB_W-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                    r <= '0;
         else if (we && tgt == MY_TGT)  r <= wdata[SUB_W-1:0];
      end
      assign sub_q[j] = r;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gpl_q       <= '0;
         irq_release <= 1'b0;
         wdog_kick   <= 1'b0;
      end else begin
         if (we && tgt == TG_LATCH) gpl_q <= wdata[GPL_W-1:0];
         irq_release <= we && (tgt == TG_IRQ);
         wdog_kick   <= we && (tgt == TG_WDOG);
      end
   end

   // R1: cleared state right after reset release
   p_reset_clear_r1: assert property (@(posedge clk)
      $rose(rst_n) |-> (fld_q == '0 && sub_q == '0 && gpl_q == '0 &&
                        !irq_release && !wdog_kick));

   // R2: no write enable, no change
   p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> ($stable(fld_q) && $stable(sub_q) && $stable(gpl_q)));

   // R7: watchdog pulse is one cycle and leaves storage untouched
   p_wdog_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wdog_kick |=> !wdog_kick);
   p_wdog_nostore_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wdog_kick |-> ($stable(fld_q) && $stable(sub_q) && $stable(gpl_q)));

   // R8: interrupt release pulse is one cycle and stores nothing
   p_irq_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_release |=> !irq_release);
   p_irq_nostore_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_release |-> ($stable(fld_q) && $stable(sub_q) && $stable(gpl_q)));
   p_pulse_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({irq_release, wdog_kick}));

endmodule

// File: rtl/ckr_keyscan.sv
module ckr_keyscan
   import ckr_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned NKEY   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  ckr_tgt_e          tgt,
   input  logic [DATA_W-1:0] wdata,
   output logic [NKEY-1:0]   pull_low
);

   logic       hit;
   logic       all_lines;
   logic       all_val;
   logic       one_val;
   logic [2:0] line_idx;

   assign hit       = we && (tgt == TG_KEYS);
   assign all_lines = wdata[5];
   assign all_val   = wdata[4];
   assign one_val   = wdata[3];
   assign line_idx  = wdata[2:0];

   for (genvar k = 0; k < int'(NKEY); k++) begin : g_line
      logic r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            r <= 1'b0;
         end else if (hit) begin
            if (all_lines)                 r <= all_val;
            else if (int'(line_idx) == k)  r <= one_val;
         end
      end
      assign pull_low[k] = r;
   end

   // R9: drive register moves only on a key-scan write
   p_keys_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> $stable(pull_low));
   // R9: broadcast form sets every line alike
   p_keys_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && all_lines) |=> (pull_low == {NKEY{$past(all_val)}}));

endmodule

// File: rtl/ctl_keyscan_if.sv
module ctl_keyscan_if
   import ckr_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned NKEY        = 8,
   parameter int unsigned GPL_W       = 2,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned FLD_W      = DATA_W - 2,
   localparam int unsigned SUB_W      = DATA_W - 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_cs_n,
   input  logic              cpu_wr_n,
   input  logic              cpu_rd_n,
   input  logic [1:0]        cpu_addr,
   input  logic [DATA_W-1:0] cpu_din,
   output logic [DATA_W-1:0] cpu_dout,
   output logic              cpu_doe,
   input  logic [NKEY-1:0]   key_sense,
   output logic [NKEY-1:0]   key_pull_low,
   output logic [FLD_W-1:0]  tone_enable,
   output logic [FLD_W-1:0]  tone_setup,
   output logic [FLD_W-1:0]  dtmf_setup,
   output logic [FLD_W-1:0]  rx_gain,
   output logic [FLD_W-1:0]  tx_gain,
   output logic [FLD_W-1:0]  spk_gain,
   output logic [FLD_W-1:0]  pad_gain,
   output logic [FLD_W-1:0]  path_sw_lo,
   output logic [FLD_W-1:0]  path_sw_hi,
   output logic [GPL_W-1:0]  gp_latch,
   output logic [SUB_W-1:0]  lcd_bias,
   output logic [SUB_W-1:0]  power_ctl,
   output logic [SUB_W-1:0]  codec_ctl,
   output logic              irq_release,
   output logic              wdog_kick
);

   // elaboration-time parameter checks
   if (DATA_W != 8) begin : g_bad_dw
      $error("ctl_keyscan_if: DATA_W must be 8 (sub-address field positions)");
   end
   if (NKEY < 1 || NKEY > 8 || NKEY > DATA_W) begin : g_bad_nkey
      $error("ctl_keyscan_if: NKEY must lie in 1..8 (3-bit line index)");
   end
   if (GPL_W < 1 || GPL_W > FLD_W) begin : g_bad_gpl
      $error("ctl_keyscan_if: GPL_W must lie in 1..DATA_W-2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("ctl_keyscan_if: SYNC_STAGES must be at least 2");
   end

   logic                           we;
   logic [1:0]                     waddr;
   logic [DATA_W-1:0]              wdata;
   ckr_tgt_e                       tgt;
   logic [CKR_NFLD-1:0][FLD_W-1:0] fld_q;
   logic [CKR_NSUB-1:0][SUB_W-1:0] sub_q;

   ckr_capture #(.DATA_W(DATA_W), .STAGES(SYNC_STAGES)) u_capture (
      .clk   (clk),
      .rst_n (rst_n),
      .cs_n  (cpu_cs_n),
      .wr_n  (cpu_wr_n),
      .addr  (cpu_addr),
      .din   (cpu_din),
      .we    (we),
      .waddr (waddr),
      .wdata (wdata)
   );

   ckr_decode #(.DATA_W(DATA_W)) u_decode (
      .addr (waddr),
      .data (wdata),
      .tgt  (tgt)
   );

   ckr_regfile #(.DATA_W(DATA_W), .GPL_W(GPL_W)) u_regfile (
      .clk         (clk),
      .rst_n       (rst_n),
      .we          (we),
      .tgt         (tgt),
      .wdata       (wdata),
      .fld_q       (fld_q),
      .sub_q       (sub_q),
      .gpl_q       (gp_latch),
      .irq_release (irq_release),
      .wdog_kick   (wdog_kick)
   );

   ckr_keyscan #(.DATA_W(DATA_W), .NKEY(NKEY)) u_keyscan (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (we),
      .tgt      (tgt),
      .wdata    (wdata),
      .pull_low (key_pull_low)
   );

   assign tone_enable = fld_q[0];
   assign tone_setup  = fld_q[1];
   assign dtmf_setup  = fld_q[2];
   assign rx_gain     = fld_q[3];
   assign tx_gain     = fld_q[4];
   assign spk_gain    = fld_q[5];
   assign pad_gain    = fld_q[6];
   assign path_sw_lo  = fld_q[7];
   assign path_sw_hi  = fld_q[8];
   assign lcd_bias    = sub_q[0];
   assign power_ctl   = sub_q[1];
   assign codec_ctl   = sub_q[2];

   // read path: bus driven only while selected and read-strobed
   assign cpu_doe  = ~cpu_cs_n & ~cpu_rd_n;
   assign cpu_dout = cpu_doe ? {{(DATA_W-NKEY){1'b0}}, key_sense} : '0;

   // R10: unused address-3 sub-addresses never reach storage or pulses
   p_unused_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (we && waddr == 2'd3 && wdata[DATA_W-1] == 1'b0) |=>
         (!irq_release && !wdog_kick && $stable(key_pull_low) &&
          $stable(fld_q) && $stable(sub_q)));

endmodule

// File: tb/test_ctl_keyscan_if.sv
`timescale 1ns/1ps
module test_ctl_keyscan_if;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cpu_cs_n = 1'b1;
   logic       cpu_wr_n = 1'b1;
   logic       cpu_rd_n = 1'b1;
   logic [1:0] cpu_addr = '0;
   logic [7:0] cpu_din = '0;
   logic [7:0] cpu_dout;
   logic       cpu_doe;
   logic [7:0] key_sense = '0;
   logic [7:0] key_pull_low;
   logic [5:0] tone_enable, tone_setup, dtmf_setup;
   logic [5:0] rx_gain, tx_gain, spk_gain, pad_gain;
   logic [5:0] path_sw_lo, path_sw_hi;
   logic [1:0] gp_latch;
   logic [3:0] lcd_bias, power_ctl, codec_ctl;
   logic       irq_release, wdog_kick;

   always #4 clk = ~clk;

   ctl_keyscan_if i_ctl_keyscan_if (
      .clk(clk), .rst_n(rst_n), .cpu_cs_n(cpu_cs_n), .cpu_wr_n(cpu_wr_n),
      .cpu_rd_n(cpu_rd_n), .cpu_addr(cpu_addr), .cpu_din(cpu_din),
      .cpu_dout(cpu_dout), .cpu_doe(cpu_doe), .key_sense(key_sense),
      .key_pull_low(key_pull_low), .tone_enable(tone_enable),
      .tone_setup(tone_setup), .dtmf_setup(dtmf_setup), .rx_gain(rx_gain),
      .tx_gain(tx_gain), .spk_gain(spk_gain), .pad_gain(pad_gain),
      .path_sw_lo(path_sw_lo), .path_sw_hi(path_sw_hi), .gp_latch(gp_latch),
      .lcd_bias(lcd_bias), .power_ctl(power_ctl), .codec_ctl(codec_ctl),
      .irq_release(irq_release), .wdog_kick(wdog_kick)
   );

   int n_chk = 0;
   int n_bad = 0;
   int seen_irq = 0, seen_wdog = 0;
   int exp_irq = 0, exp_wdog = 0;
   logic [5:0] e_fld [9];
   logic [3:0] e_sub [3];
   logic [1:0] e_gpl;
   logic [7:0] e_keys;

   // pulse monitor, sampled away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (irq_release) seen_irq++;
         if (wdog_kick)   seen_wdog++;
      end
   end

   task automatic chk(input string tag, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 9; i++) e_fld[i] = '0;
      for (int i = 0; i < 3; i++) e_sub[i] = '0;
      e_gpl  = '0;
      e_keys = '0;
   endtask

   // expected effect of one selected write
   task automatic model_write(input logic [1:0] a, input logic [7:0] d);
      logic [1:0] sub = d[7:6];
      logic [1:0] fn  = d[5:4];
      case (a)
         2'd0: if (sub != 2'd3) e_fld[sub] = d[5:0];
         2'd1: e_fld[3 + sub] = d[5:0];
         2'd2: begin
            if (sub == 2'd0)      e_fld[7] = d[5:0];
            else if (sub == 2'd1) e_fld[8] = d[5:0];
            else if (sub == 2'd2) e_gpl = d[1:0];
            else                  exp_wdog++;
         end
         default: begin
            if (sub == 2'd2) begin
               if (d[5]) e_keys = {8{d[4]}};
               else      e_keys[d[2:0]] = d[3];
            end else if (sub == 2'd3) begin
               if (fn == 2'd0) exp_irq++;
               else            e_sub[fn - 2'd1] = d[3:0];
            end
         end
      endcase
   endtask

   task automatic check_all(input string ctx);
      chk({ctx, " R4 tone_enable"}, int'(tone_enable), int'(e_fld[0]));
      chk({ctx, " R4 tone_setup"},  int'(tone_setup),  int'(e_fld[1]));
      chk({ctx, " R4 dtmf_setup"},  int'(dtmf_setup),  int'(e_fld[2]));
      chk({ctx, " R5 rx_gain"},     int'(rx_gain),     int'(e_fld[3]));
      chk({ctx, " R5 tx_gain"},     int'(tx_gain),     int'(e_fld[4]));
      chk({ctx, " R5 spk_gain"},    int'(spk_gain),    int'(e_fld[5]));
      chk({ctx, " R5 pad_gain"},    int'(pad_gain),    int'(e_fld[6]));
      chk({ctx, " R6 path_sw_lo"},  int'(path_sw_lo),  int'(e_fld[7]));
      chk({ctx, " R6 path_sw_hi"},  int'(path_sw_hi),  int'(e_fld[8]));
      chk({ctx, " R6 gp_latch"},    int'(gp_latch),    int'(e_gpl));
      chk({ctx, " R8 lcd_bias"},    int'(lcd_bias),    int'(e_sub[0]));
      chk({ctx, " R8 power_ctl"},   int'(power_ctl),   int'(e_sub[1]));
      chk({ctx, " R8 codec_ctl"},   int'(codec_ctl),   int'(e_sub[2]));
      chk({ctx, " R9 key_pull_low"}, int'(key_pull_low), int'(e_keys));
      chk({ctx, " R8 irq pulses"},  seen_irq,  exp_irq);
      chk({ctx, " R7 wdog pulses"}, seen_wdog, exp_wdog);
   endtask

   // bus write: select, address and data held across the strobe and 4 clocks after
   task automatic do_write(input logic [1:0] a, input logic [7:0] d, input bit sel);
      @(negedge clk);
      cpu_addr = a; cpu_din = d; cpu_cs_n = !sel;
      @(negedge clk);
      cpu_wr_n = 1'b0;
      repeat (2) @(negedge clk);
      cpu_wr_n = 1'b1;
      repeat (4) @(negedge clk);
      cpu_cs_n = 1'b1;
      if (sel) model_write(a, d);
   endtask

   task automatic do_read_check(input logic [7:0] keys, input bit cs, input bit rd);
      @(negedge clk);
      key_sense = keys; cpu_cs_n = !cs; cpu_rd_n = !rd;
      #2;
      chk("R3 doe", int'(cpu_doe), int'(cs && rd));
      if (cs && rd) chk("R3 dout", int'(cpu_dout), int'(keys));
      @(negedge clk);
      cpu_cs_n = 1'b1; cpu_rd_n = 1'b1;
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(200000 * 8);
      n_bad++;
      $display("FAIL watchdog: run did not end, got timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'h00C0FFEE));
      model_reset();
      repeat (3) @(negedge clk);
      // R1: state while in reset
      check_all("R1 in-reset");
      chk("R1 doe", int'(cpu_doe), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1 after-reset");

      // R3: read path combinations
      do_read_check(8'hA5, 1'b1, 1'b1);
      do_read_check(8'h3C, 1'b0, 1'b1);
      do_read_check(8'hFF, 1'b1, 1'b0);
      do_read_check(8'h00, 1'b1, 1'b1);

      // R4 directed
      do_write(2'd0, 8'b00_101010, 1'b1); check_all("R4 tone_en");
      do_write(2'd0, 8'b01_010101, 1'b1); check_all("R4 tone_set");
      do_write(2'd0, 8'b10_111111, 1'b1); check_all("R4 dtmf");
      do_write(2'd0, 8'b11_110011, 1'b1); check_all("R4 sub3 nostore");
      // R5 directed
      for (int s = 0; s < 4; s++) begin
         do_write(2'd1, {s[1:0], 6'h30 + 6'(s)}, 1'b1); check_all("R5 gain");
      end
      // R6 directed
      do_write(2'd2, 8'b00_100001, 1'b1); check_all("R6 path lo");
      do_write(2'd2, 8'b01_011110, 1'b1); check_all("R6 path hi");
      do_write(2'd2, 8'b10_111110, 1'b1); check_all("R6 latch");
      // R7 watchdog kick
      do_write(2'd2, 8'b11_111111, 1'b1); check_all("R7 wdog");
      // R8 functions
      do_write(2'd3, 8'b11_00_1111, 1'b1); check_all("R8 irq");
      do_write(2'd3, 8'b11_01_1001, 1'b1); check_all("R8 lcd");
      do_write(2'd3, 8'b11_10_0110, 1'b1); check_all("R8 pwr");
      do_write(2'd3, 8'b11_11_1010, 1'b1); check_all("R8 codec");
      // R9 key drive: all low, release line 5, then all released, pull line 0
      do_write(2'd3, 8'b10_1_1_0000, 1'b1); check_all("R9 all drive");
      do_write(2'd3, 8'b10_0_0_0101, 1'b1); check_all("R9 release 5");
      do_write(2'd3, 8'b10_1_0_1111, 1'b1); check_all("R9 all release");
      do_write(2'd3, 8'b10_0_1_1000, 1'b1); check_all("R9 pull 0");
      do_write(2'd3, 8'b10_0_1_1111, 1'b1); check_all("R9 pull 7");
      // R10 unused sub-addresses of address 3
      do_write(2'd3, 8'b00_111111, 1'b1); check_all("R10 sub0");
      do_write(2'd3, 8'b01_000000, 1'b1); check_all("R10 sub1");
      // R2 writes while deselected are ignored
      do_write(2'd1, 8'b00_000000, 1'b0); check_all("R2 cs high");
      do_write(2'd3, 8'b11_00_0000, 1'b0); check_all("R2 cs high irq");
      do_write(2'd2, 8'b11_000000, 1'b0); check_all("R2 cs high wdog");

      // constrained random mix
      for (int n = 0; n < 400; n++) begin
         logic [1:0] a = 2'($urandom());
         logic [7:0] d = 8'($urandom());
         bit sel = ($urandom() % 5) != 0;
         do_write(a, d, sel);
         check_all(sel ? "R2 random write" : "R2 random deselected");
         if ((n % 8) == 0)
            do_read_check(8'($urandom()), bit'($urandom()), bit'($urandom()));
      end

      // R1: reset in mid-run clears everything again
      @(negedge clk);
      rst_n = 1'b0;
      model_reset();
      @(negedge clk);
      check_all("R1 re-reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1 re-release");

      finish_run();
   end

endmodule